// File: doc/BRIEF.md
# Sector Error-Correction Pass Sequencer

This block runs the error-handling flow for one buffered data sector. When a sector start strobe arrives it samples the sector descriptor (mode number, extended-architecture flag, form flag, short-sector flag) and the processing configuration (operation code and repeat count). It then decides which work the sector may receive: an integrity check over the sector's error-detection code (EDC), correction passes over the P and Q parity, both, or neither. It issues that work to external engines one request at a time.

The engines do the arithmetic and are outside this block. One computes the EDC and reports pass or fail. One computes the P and Q syndromes and reports whether each is zero. One runs a single P or Q correction pass and reports whether the sector is beyond repair. This block orders the work, records sticky status flags for software, and pulses an error interrupt when a pass gives up.

There is no data stream at the block's edge; each engine link is a level request and a one-cycle done pulse. A request stays high until its done pulse. The engine may accept the next request at the earliest on the cycle after a done pulse, and it receives no back-pressure other than the held request.

Top module: `sector_fix_seq`

## Requirements
- R1: `cfg_mode` picks the work. 0 means nothing. 1 means an EDC check only. 2 means a P pass. 3 means a Q pass. 4 means P then Q. 5 means Q then P. Codes 2 to 5 also include the EDC check. Codes 6 and 7 mean nothing.
- R2: Codes 4 and 5 run `cfg_repeat` full iterations, and a value of 0 counts as 1. Codes 2 and 3 run one pass per iteration and a single iteration.
- R3: When the EDC check is enabled it runs twice: once before the first syndrome request and once after all other work. With code 1 the two checks run back to back.
- R4: When correction is enabled the syndromes are computed first. If both are zero, no correction pass runs.
- R5: With `auto_detect` high, only two kinds of sector receive full processing: mode 1, and mode 2 with `sec_xa`=1 and `sec_form2`=0. A sector of mode 0, mode 3, or mode 2 with `sec_xa`=0 receives no request at all. With `auto_detect` low, the sector fields are ignored.
- R6: With `auto_detect` high, a mode 2 sector with `sec_xa`=1 and `sec_form2`=1 receives the EDC checks only, whatever correction the code asks for.
- R7: After each iteration the syndromes are recomputed. If both are zero, the remaining iterations are skipped.
- R8: If a pass reports the sector as uncorrectable, `err_irq` pulses for exactly one cycle and `st_uncorr` is set. No further pass runs, and the syndromes and the final EDC check still follow.
- R9: `sec_short` sampled with the start strobe sets `st_uncorr` without an interrupt.
- R10: `st_syn_p_nz` and `st_syn_q_nz` show the last syndrome result of the sector (1 means non-zero). A start clears them, so they stay 0 if no syndrome runs.
- R11: A failing first EDC check sets `st_edc_pre_bad`. A failing second EDC check sets `st_edc_post_bad`. Both are sticky.
- R12: `busy` rises in the cycle after an accepted start and stays high through a one-cycle `done` pulse, then falls. A start seen while `busy` is high is ignored.
- R13: The sticky flags clear only through `clr_sticky`, with bit 0 for `st_uncorr`, bit 1 for `st_edc_pre_bad` and bit 2 for `st_edc_post_bad`. A set in the same cycle wins over the clear.
- R14: At most one request is high at a time. `pass_sel_q` is stable while `pass_req` waits for its done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_start | input | 1 | Sector start strobe |
| sec_mode | input | 2 | Sector mode number |
| sec_xa | input | 1 | Mode 2 sector carries the extended subheader |
| sec_form2 | input | 1 | Mode 2 sector is form 2 |
| sec_short | input | 1 | Upstream saw a short sector |
| auto_detect | input | 1 | Gate processing by sector fields |
| cfg_mode | input | 3 | Operation code |
| cfg_repeat | input | 2 | Iteration count for two-pass codes |
| edc_req | output | 1 | EDC check request |
| edc_done | input | 1 | EDC engine done pulse |
| edc_ok | input | 1 | EDC matched, valid with done |
| syn_req | output | 1 | Syndrome request |
| syn_done | input | 1 | Syndrome engine done pulse |
| syn_p_zero | input | 1 | P syndrome zero, valid with done |
| syn_q_zero | input | 1 | Q syndrome zero, valid with done |
| pass_req | output | 1 | Correction pass request |
| pass_sel_q | output | 1 | 1 for a Q pass, 0 for a P pass |
| pass_done | input | 1 | Pass engine done pulse |
| pass_uncorr | input | 1 | Pass found the sector uncorrectable |
| busy | output | 1 | Sector in progress |
| done | output | 1 | One-cycle end-of-sector pulse |
| err_irq | output | 1 | Uncorrectable interrupt pulse |
| st_syn_p_nz | output | 1 | Last P syndrome non-zero |
| st_syn_q_nz | output | 1 | Last Q syndrome non-zero |
| st_uncorr | output | 1 | Sticky uncorrectable flag |
| st_edc_pre_bad | output | 1 | Sticky first-EDC failure |
| st_edc_post_bad | output | 1 | Sticky second-EDC failure |
| clr_sticky | input | 3 | Write-one-to-clear for the sticky flags |

## Verification
Almost any wrong internal state changes the order or the number of engine requests. A wrong iteration count, a lost abort flag, a bad step index or a bad sector class appears at the request pins within one engine round trip. The bench therefore logs every request and compares the log with an arithmetic model over every operation code, repeat value, syndrome-clearing point and failing-pass position. A stuck flag or a misrouted done shows up in the status bits or the done pulse in the cycle after the sector ends.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int MODE_W = 3;
  localparam int REP_W  = 2;
  localparam int SMODE_W = 2;
  localparam int NFLAG  = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EDC_PRE, ST_SYN, ST_PASS, ST_EDC_POST, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    ORD_P, ORD_Q, ORD_PQ, ORD_QP
  } pass_order_e;
endpackage

// File: rtl/sfs_gate.sv
module sfs_gate
  import sfs_pkg::*;
(
  input  logic               auto_detect,
  input  logic [SMODE_W-1:0] sec_mode,
  input  logic               sec_xa,
  input  logic               sec_form2,
  input  logic [MODE_W-1:0]  cfg_mode,
  input  logic [REP_W-1:0]   cfg_repeat,
  output logic               do_edc,
  output logic               do_ecc,
  output pass_order_e        order,
  output logic [REP_W-1:0]   n_iter
);
  logic cls_edc, cls_ecc, cfg_edc, cfg_ecc;

  // sector class from descriptor
  always_comb begin
    cls_edc = 1'b0;
    cls_ecc = 1'b0;
    if (!auto_detect) begin
      cls_edc = 1'b1;
      cls_ecc = 1'b1;
    end else begin
      case (sec_mode)
        2'd1: begin cls_edc = 1'b1; cls_ecc = 1'b1; end
        2'd2: if (sec_xa) begin
          cls_edc = 1'b1;
          cls_ecc = !sec_form2;
        end
        default: ;
      endcase
    end
  end

  // operation code decode
  always_comb begin
    cfg_edc = 1'b0;
    cfg_ecc = 1'b0;
    order   = ORD_P;
    case (cfg_mode)
      3'd1: cfg_edc = 1'b1;
      3'd2: begin cfg_edc = 1'b1; cfg_ecc = 1'b1; order = ORD_P;  end
      3'd3: begin cfg_edc = 1'b1; cfg_ecc = 1'b1; order = ORD_Q;  end
      3'd4: begin cfg_edc = 1'b1; cfg_ecc = 1'b1; order = ORD_PQ; end
      3'd5: begin cfg_edc = 1'b1; cfg_ecc = 1'b1; order = ORD_QP; end
      default: ;
    endcase
  end

  assign do_edc = cls_edc && cfg_edc;
  assign do_ecc = cls_ecc && cfg_ecc;

  always_comb begin
    if ((order == ORD_PQ || order == ORD_QP) && cfg_repeat != '0)
      n_iter = cfg_repeat;
    else
      n_iter = REP_W'(1);
  end
endmodule

// File: rtl/sfs_order.sv
module sfs_order
  import sfs_pkg::*;
(
  input  pass_order_e order,
  input  logic        step,
  output logic        sel_q,
  output logic        last
);
  always_comb begin
    case (order)
      ORD_P:   begin sel_q = 1'b0;  last = 1'b1; end
      ORD_Q:   begin sel_q = 1'b1;  last = 1'b1; end
      ORD_PQ:  begin sel_q = step;  last = step; end
      default: begin sel_q = !step; last = step; end
    endcase
  end
endmodule

// File: rtl/sfs_sticky.sv
module sfs_sticky #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr[i]) |=> q[i]);
    p_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
  end
endmodule

// File: rtl/sector_fix_seq.sv
module sector_fix_seq
  import sfs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_start,
  input  logic [SMODE_W-1:0] sec_mode,
  input  logic               sec_xa,
  input  logic               sec_form2,
  input  logic               sec_short,
  input  logic               auto_detect,
  input  logic [MODE_W-1:0]  cfg_mode,
  input  logic [REP_W-1:0]   cfg_repeat,
  output logic               edc_req,
  input  logic               edc_done,
  input  logic               edc_ok,
  output logic               syn_req,
  input  logic               syn_done,
  input  logic               syn_p_zero,
  input  logic               syn_q_zero,
  output logic               pass_req,
  output logic               pass_sel_q,
  input  logic               pass_done,
  input  logic               pass_uncorr,
  output logic               busy,
  output logic               done,
  output logic               err_irq,
  output logic               st_syn_p_nz,
  output logic               st_syn_q_nz,
  output logic               st_uncorr,
  output logic               st_edc_pre_bad,
  output logic               st_edc_post_bad,
  input  logic [NFLAG-1:0]   clr_sticky
);
  seq_state_e         state;
  logic               cap_auto, cap_xa, cap_form2;
  logic [SMODE_W-1:0] cap_smode;
  logic [MODE_W-1:0]  cap_mode;
  logic [REP_W-1:0]   cap_rep;
  logic               step, aborted;
  logic [REP_W-1:0]   iter_cnt;

  logic               g_auto, g_xa, g_form2;
  logic [SMODE_W-1:0] g_smode;
  logic [MODE_W-1:0]  g_mode;
  logic [REP_W-1:0]   g_rep;
  logic               do_edc, do_ecc, sel_q, last;
  pass_order_e        order;
  logic [REP_W-1:0]   n_iter;
  logic               idle, accept, pass_fail;
  logic [NFLAG-1:0]   flag_set, flag_q;

  assign idle   = (state == ST_IDLE);
  assign accept = idle && sec_start;

  // gate sees live fields while idle, sampled fields afterwards
  assign g_auto  = idle ? auto_detect : cap_auto;
  assign g_smode = idle ? sec_mode    : cap_smode;
  assign g_xa    = idle ? sec_xa      : cap_xa;
  assign g_form2 = idle ? sec_form2   : cap_form2;
  assign g_mode  = idle ? cfg_mode    : cap_mode;
  assign g_rep   = idle ? cfg_repeat  : cap_rep;

  sfs_gate u_gate (
    .auto_detect(g_auto), .sec_mode(g_smode), .sec_xa(g_xa),
    .sec_form2(g_form2), .cfg_mode(g_mode), .cfg_repeat(g_rep),
    .do_edc(do_edc), .do_ecc(do_ecc), .order(order), .n_iter(n_iter)
  );

  sfs_order u_order (
    .order(order), .step(step), .sel_q(sel_q), .last(last)
  );

  assign pass_fail = (state == ST_PASS) && pass_done && pass_uncorr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cap_auto    <= 1'b0;
      cap_smode   <= '0;
      cap_xa      <= 1'b0;
      cap_form2   <= 1'b0;
      cap_mode    <= '0;
      cap_rep     <= '0;
      step        <= 1'b0;
      aborted     <= 1'b0;
      iter_cnt    <= '0;
      st_syn_p_nz <= 1'b0;
      st_syn_q_nz <= 1'b0;
      err_irq     <= 1'b0;
    end else begin
      err_irq <= pass_fail;
      case (state)
        ST_IDLE: if (sec_start) begin
          cap_auto    <= auto_detect;
          cap_smode   <= sec_mode;
          cap_xa      <= sec_xa;
          cap_form2   <= sec_form2;
          cap_mode    <= cfg_mode;
          cap_rep     <= cfg_repeat;
          step        <= 1'b0;
          aborted     <= 1'b0;
          iter_cnt    <= '0;
          st_syn_p_nz <= 1'b0;
          st_syn_q_nz <= 1'b0;
          state       <= do_edc ? ST_EDC_PRE : ST_DONE;
        end
        ST_EDC_PRE: if (edc_done)
          state <= do_ecc ? ST_SYN : ST_EDC_POST;
        ST_SYN: if (syn_done) begin
          st_syn_p_nz <= !syn_p_zero;
          st_syn_q_nz <= !syn_q_zero;
          step        <= 1'b0;
          if (aborted || (syn_p_zero && syn_q_zero) || iter_cnt == n_iter)
            state <= ST_EDC_POST;
          else
            state <= ST_PASS;
        end
        ST_PASS: if (pass_done) begin
          if (pass_uncorr) begin
            aborted <= 1'b1;
            state   <= ST_SYN;
          end else if (last) begin
            iter_cnt <= iter_cnt + REP_W'(1);
            state    <= ST_SYN;
          end else begin
            step <= 1'b1;
          end
        end
        ST_EDC_POST: if (edc_done) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign edc_req    = (state == ST_EDC_PRE) || (state == ST_EDC_POST);
  assign syn_req    = (state == ST_SYN);
  assign pass_req   = (state == ST_PASS);
  assign pass_sel_q = sel_q;
  assign busy       = !idle;
  assign done       = (state == ST_DONE);

  assign flag_set[0] = (accept && sec_short) || pass_fail;
  assign flag_set[1] = (state == ST_EDC_PRE)  && edc_done && !edc_ok;
  assign flag_set[2] = (state == ST_EDC_POST) && edc_done && !edc_ok;

  sfs_sticky #(.W(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(clr_sticky), .q(flag_q)
  );

  assign st_uncorr       = flag_q[0];
  assign st_edc_pre_bad  = flag_q[1];
  assign st_edc_post_bad = flag_q[2];

  p_one_req_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({edc_req, syn_req, pass_req}));
  p_sel_stable_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_req && !pass_done) |=> (pass_req && $stable(pass_sel_q)));
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> st_uncorr);
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq);
  p_iter_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (iter_cnt <= n_iter));
endmodule

// File: tb/sector_fix_seq_tb_top.sv
module sector_fix_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_start = 0, sec_xa = 0, sec_form2 = 0, sec_short = 0, auto_detect = 0;
  logic [1:0] sec_mode = 0, cfg_repeat = 0;
  logic [2:0] cfg_mode = 0, clr_sticky = 0;
  logic edc_done = 0, edc_ok = 0, syn_done = 0, syn_p_zero = 0, syn_q_zero = 0;
  logic pass_done = 0, pass_uncorr = 0;
  logic edc_req, syn_req, pass_req, pass_sel_q, busy, done, err_irq;
  logic st_syn_p_nz, st_syn_q_nz, st_uncorr, st_edc_pre_bad, st_edc_post_bad;

  int tests = 0, fails = 0;
  int sc_fp, sc_fq, sc_ua, sc_lat, passes;
  int got_tr[0:31], exp_tr[0:31];
  int got_n, exp_n, irq_cnt;
  int eng_cnt = 0, eng_kind = 0;
  bit e_syn_p, e_syn_q, e_pre, e_post, e_unc;
  int e_irq;

  always #5 clk = ~clk;

  sector_fix_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sec_start(sec_start), .sec_mode(sec_mode),
    .sec_xa(sec_xa), .sec_form2(sec_form2), .sec_short(sec_short),
    .auto_detect(auto_detect), .cfg_mode(cfg_mode), .cfg_repeat(cfg_repeat),
    .edc_req(edc_req), .edc_done(edc_done), .edc_ok(edc_ok),
    .syn_req(syn_req), .syn_done(syn_done), .syn_p_zero(syn_p_zero),
    .syn_q_zero(syn_q_zero), .pass_req(pass_req), .pass_sel_q(pass_sel_q),
    .pass_done(pass_done), .pass_uncorr(pass_uncorr), .busy(busy),
    .done(done), .err_irq(err_irq), .st_syn_p_nz(st_syn_p_nz),
    .st_syn_q_nz(st_syn_q_nz), .st_uncorr(st_uncorr),
    .st_edc_pre_bad(st_edc_pre_bad), .st_edc_post_bad(st_edc_post_bad),
    .clr_sticky(clr_sticky)
  );

  // engine model, log codes: 1 EDC, 2 syndrome, 3 P pass, 4 Q pass
  initial forever begin
    @(negedge clk);
    if (err_irq) irq_cnt++;
    if (edc_done || syn_done || pass_done) begin
      edc_done = 0; syn_done = 0; pass_done = 0;
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        case (eng_kind)
          1: begin edc_ok = (passes >= sc_fp) && (passes >= sc_fq); edc_done = 1; end
          2: begin syn_p_zero = passes >= sc_fp; syn_q_zero = passes >= sc_fq; syn_done = 1; end
          default: begin passes++; pass_uncorr = (passes == sc_ua); pass_done = 1; end
        endcase
      end
    end else if (edc_req || syn_req || pass_req) begin
      eng_kind = edc_req ? 1 : (syn_req ? 2 : 3);
      if (got_n < 32) got_tr[got_n] = edc_req ? 1 : (syn_req ? 2 : (pass_sel_q ? 4 : 3));
      got_n++;
      eng_cnt = sc_lat;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int c);
    if (exp_n < 32) exp_tr[exp_n] = c;
    exp_n++;
  endtask

  // arithmetic model of the requirements
  task automatic model(input bit au, input int sm, input bit xa, input bit f2,
                       input bit sh, input int cm, input int rp);
    bit cedc, cecc, dedc, decc, ab, ran_syn;
    int n, np, ps, first, second;
    cedc = 1; cecc = 1;
    if (au) begin
      if (sm == 1) begin cedc = 1; cecc = 1; end          // R5
      else if (sm == 2 && xa) begin cedc = 1; cecc = !f2; end  // R6
      else begin cedc = 0; cecc = 0; end                   // R5
    end
    dedc = cedc && (cm >= 1 && cm <= 5);                  // R1
    decc = cecc && (cm >= 2 && cm <= 5);
    n  = (cm >= 4 && cm <= 5 && rp != 0) ? rp : 1;       // R2
    np = (cm >= 4) ? 2 : 1;
    first  = (cm == 3 || cm == 5) ? 4 : 3;
    second = (first == 3) ? 4 : 3;
    exp_n = 0; ps = 0; ab = 0; ran_syn = 0; e_irq = 0;
    if (dedc) push(1);                                    // R3
    if (decc) begin
      push(2); ran_syn = 1;                               // R4
      if (!(sc_fp == 0 && sc_fq == 0)) begin
        for (int it = 0; it < n; it++) begin
          for (int k = 0; k < np && !ab; k++) begin
            push(k == 0 ? first : second);
            ps++;
            if (ps == sc_ua) begin ab = 1; e_irq = 1; end // R8
          end
          push(2);
          if (ab || (ps >= sc_fp && ps >= sc_fq)) break;  // R7
        end
      end
    end
    if (dedc) push(1);
    e_syn_p = ran_syn && (ps < sc_fp);
    e_syn_q = ran_syn && (ps < sc_fq);
    e_pre   = dedc && (sc_fp > 0 || sc_fq > 0);
    e_post  = dedc && !(ps >= sc_fp && ps >= sc_fq);
    e_unc   = ab || sh;                                   // R9
  endtask

  task automatic run_sector(input bit au, input int sm, input bit xa, input bit f2,
                            input bit sh, input int cm, input int rp,
                            input int fp, input int fq, input int ua, input int lat,
                            input bit restart, input string tag);
    bit same;
    int guard;
    @(negedge clk); clr_sticky = 3'b111;
    @(negedge clk); clr_sticky = 3'b000;
    sc_fp = fp; sc_fq = fq; sc_ua = ua; sc_lat = lat; passes = 0;
    got_n = 0; irq_cnt = 0;
    auto_detect = au; sec_mode = 2'(sm); sec_xa = xa; sec_form2 = f2;
    sec_short = sh; cfg_mode = 3'(cm); cfg_repeat = 2'(rp); sec_start = 1;
    @(negedge clk);
    sec_start = 0; sec_short = 0;
    check(busy == 1'b1, {tag, " R12 busy after start"}, busy, 1);
    if (restart) begin
      // R12: a second strobe mid-sector with other settings must be ignored
      @(negedge clk);
      cfg_mode = 3'd1; sec_short = 1; sec_start = 1;
      @(negedge clk);
      sec_start = 0; sec_short = 0;
    end
    guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    model(au, sm, xa, f2, sh, cm, rp);
    same = (got_n == exp_n);
    for (int i = 0; i < 32 && i < exp_n; i++) if (got_tr[i] != exp_tr[i]) same = 0;
    check(same, {tag, " R14 request order"}, got_n, exp_n);
    check({st_syn_p_nz, st_syn_q_nz} == {e_syn_p, e_syn_q}, {tag, " R10 syndrome bits"},
          {st_syn_p_nz, st_syn_q_nz}, {e_syn_p, e_syn_q});
    check({st_edc_pre_bad, st_edc_post_bad} == {e_pre, e_post}, {tag, " R11 EDC flags"},
          {st_edc_pre_bad, st_edc_post_bad}, {e_pre, e_post});
    @(negedge clk);
    check(st_uncorr == e_unc, {tag, " R8 uncorrectable flag"}, st_uncorr, e_unc);
    check(irq_cnt == e_irq, {tag, " R8 irq pulses"}, irq_cnt, e_irq);
    check(busy == 1'b0 && done == 1'b0, {tag, " R12 idle after done"}, busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int fvals[4];
    int uvals[3];
    int idx;
    fvals[0] = 0; fvals[1] = 1; fvals[2] = 2; fvals[3] = 9;
    uvals[0] = 0; uvals[1] = 1; uvals[2] = 3;
    repeat (3) @(negedge clk);
    check(!busy && !done && !edc_req && !syn_req && !pass_req, "R12 reset idle", busy, 0);
    check({st_uncorr, st_edc_pre_bad, st_edc_post_bad, err_irq} == 4'b0,
          "R13 reset flags", st_uncorr, 0);
    rst_n = 1;
    // R1 R2 R4 R7 R8 R3 sweep over codes, repeats, clearing points, failing pass
    idx = 0;
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 4; r++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++)
            for (int u = 0; u < 3; u++) begin
              run_sector(1, 1, 0, 0, 0, m, r, fvals[a], fvals[b], uvals[u],
                         1 + idx % 3, 0, "R1 R2 R3 R4 R7 sweep");
              idx++;
            end
    // R5 R6 sector class sweep, auto on and off
    for (int au = 0; au < 2; au++)
      for (int sm = 0; sm < 4; sm++)
        for (int x = 0; x < 2; x++)
          for (int f = 0; f < 2; f++)
            run_sector(au[0], sm, x[0], f[0], 0, 4, 2, 1, 2, 0, 2, 0, "R5 R6 class");
    // R9 short sector, no interrupt
    run_sector(1, 1, 0, 0, 1, 2, 0, 0, 0, 0, 1, 0, "R9 short");
    // R12 strobe while busy ignored
    run_sector(0, 0, 0, 0, 0, 5, 3, 9, 9, 0, 3, 1, "R12 restart");
    // R13 sticky hold across a clean sector without clearing
    run_sector(1, 1, 0, 0, 0, 4, 1, 1, 9, 1, 1, 0, "R13 setup");
    @(negedge clk);
    sc_fp = 0; sc_fq = 0; sc_ua = 0; passes = 0;
    cfg_mode = 3'd1; sec_start = 1;
    @(negedge clk); sec_start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check(st_uncorr && st_edc_pre_bad && st_edc_post_bad, "R13 flags hold", st_uncorr, 1);
    // R13 set beats clear in the same cycle
    sec_short = 1; sec_start = 1; clr_sticky = 3'b111; cfg_mode = 3'd0;
    @(negedge clk);
    sec_start = 0; sec_short = 0; clr_sticky = 3'b000;
    check(st_uncorr == 1'b1, "R13 set wins", st_uncorr, 1);
    check(st_edc_pre_bad == 1'b0 && st_edc_post_bad == 1'b0, "R13 clear", st_edc_pre_bad, 0);
    @(negedge clk); @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule